// File: doc/BRIEF.md
# Home-Node Directory Coherence Controller

This block is the home-node engine that keeps a group of memory blocks coherent across a fixed set of caching nodes. For every block it keeps one entry: a presence vector with one bit per node, a dirty flag, and a busy flag. A requester node presents a read or a write for a block. The controller looks up the entry and decides what to do. It may grant at once. It may send invalidations only to the nodes whose presence bits are set. Or it may hand the request to the single node that holds a modified copy. It then counts the acknowledgements that come back, grants the request when that applies, and writes the new entry.

One transaction runs at a time. The busy flag of the addressed block is set when a request is taken and is cleared only when the transaction commits. For a block held dirty by another node, the home does not supply data. The owner answers the requester directly and then acknowledges to the home, so the home updates its entry off the critical path. The node network, the data storage, and any reduced-size directory formats are outside this block.

Top module: `dirc_home`

## Requirements
- R1: After reset, `req_ready` is 1 and `msg_valid` is 0. Node ids and block addresses are plain binary.
- R2: A read from a node whose presence bit is clear, to a clean block, produces exactly one message in the cycle after acceptance. That message is a data grant (`msg_cmd` = 1) to the requester. The requester's presence bit is then set.
- R3: A request from a node whose presence bit is already set counts as an upgrade. This holds for a read of any block, and for a write to a block that node owns dirty. The home returns a grant without data (`msg_cmd` = 2) to the requester and sends no other message.
- R4: A write to a clean block sends one invalidation (`msg_cmd` = 3) per cycle. It goes to each node whose presence bit is set, excluding the requester, in ascending node order. After the last acknowledgement the requester gets a grant: data (1) if it was not a sharer, no data (2) if it was.
- R5: After a write commits, the entry marks only the writer, with the dirty flag set. A later read or write by another node is therefore forwarded to that writer alone.
- R6: A read to a block held dirty by another node sends one read-forward (`msg_cmd` = 4) to the owner and no grant from the home. After one acknowledgement the entry marks both owner and requester as sharers, and the dirty flag is clear.
- R7: A write to a block held dirty by another node sends one write-forward (`msg_cmd` = 5) to the owner and no grant from the home. After one acknowledgement the requester is the sole dirty owner.
- R8: `req_ready` falls in the cycle after a request is accepted. It stays low while any acknowledgement is outstanding, and it returns high in the cycle after the transaction's final step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request taken on this edge when both are high |
| req_write | input | 1 | 1 = write (exclusive) request, 0 = read |
| req_node | input | NW | Requester node id |
| req_blk | input | BW | Block address |
| msg_valid | output | 1 | Outgoing message valid |
| msg_dest | output | NW | Destination node id |
| msg_cmd | output | 3 | 1 data grant, 2 grant without data, 3 invalidate, 4 read-forward, 5 write-forward |
| ack_valid | input | 1 | One acknowledgement from a node |

## Verification
A wrong presence vector or dirty flag in an entry cannot be seen while that entry sits idle. It appears on the next request to the same block, either as a message to the wrong node or as a missing or extra invalidation. For that reason every scenario is followed by a request whose message list exposes the entry just written. A broken acknowledgement count shows up within one cycle of the expected final acknowledgement, as `req_ready` going high too early, or as a grant that comes too late or not at all.

// File: rtl/dirc_pkg.sv
package dirc_pkg;
  typedef enum logic [2:0] {
    CMD_NONE       = 3'd0,
    CMD_GRANT_DATA = 3'd1,
    CMD_GRANT_UPG  = 3'd2,
    CMD_INVAL      = 3'd3,
    CMD_FWD_RD     = 3'd4,
    CMD_FWD_WR     = 3'd5
  } dirc_cmd_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2,
    ST_DONE  = 2'd3
  } dirc_state_e;
endpackage

// File: rtl/dirc_table.sv
module dirc_table #(
  parameter int NODES  = 4,
  parameter int BLOCKS = 8,
  parameter int BW     = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [BW-1:0]    rd_blk,
  output logic [NODES-1:0] rd_pres,
  output logic             rd_dirty,
  output logic             rd_busy,
  input  logic             set_busy,
  input  logic             commit,
  input  logic [BW-1:0]    wr_blk,
  input  logic [NODES-1:0] wr_pres,
  input  logic             wr_dirty
);
  logic [NODES-1:0] pres_q  [BLOCKS];
  logic             dirty_q [BLOCKS];
  logic             busy_q  [BLOCKS];

  for (genvar b = 0; b < BLOCKS; b++) begin : g_entry
    logic [NODES-1:0] pres_d;
    logic             dirty_d;
    logic             busy_d;
    logic             hit_set;
    logic             hit_wr;

    assign hit_set = set_busy && (rd_blk == BW'(b));
    assign hit_wr  = commit && (wr_blk == BW'(b));

    always_comb begin
      pres_d  = pres_q[b];
      dirty_d = dirty_q[b];
      busy_d  = busy_q[b];
      if (hit_set) busy_d = 1'b1;
      if (hit_wr) begin
        pres_d  = wr_pres;
        dirty_d = wr_dirty;
        busy_d  = 1'b0;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pres_q[b]  <= '0;
        dirty_q[b] <= 1'b0;
        busy_q[b]  <= 1'b0;
      end else if (hit_set || hit_wr) begin
        pres_q[b]  <= pres_d;
        dirty_q[b] <= dirty_d;
        busy_q[b]  <= busy_d;
      end
    end
  end

  assign rd_pres  = pres_q[rd_blk];
  assign rd_dirty = dirty_q[rd_blk];
  assign rd_busy  = busy_q[rd_blk];
endmodule

// File: rtl/dirc_plan.sv
module dirc_plan
  import dirc_pkg::*;
#(
  parameter int NODES = 4,
  parameter int NW    = 2
) (
  input  logic             is_write,
  input  logic [NW-1:0]    node,
  input  logic [NODES-1:0] pres,
  input  logic             dirty,
  output logic [NODES-1:0] targets,
  output dirc_cmd_e        tgt_cmd,
  output logic             need_grant,
  output dirc_cmd_e        grant_cmd,
  output logic [NODES-1:0] new_pres,
  output logic             new_dirty
);
  logic [NODES-1:0] self_bit;
  logic             hit;

  assign self_bit = NODES'(1) << node;
  assign hit      = |(pres & self_bit);

  always_comb begin
    targets    = '0;
    tgt_cmd    = CMD_INVAL;
    need_grant = 1'b1;
    grant_cmd  = hit ? CMD_GRANT_UPG : CMD_GRANT_DATA;
    new_pres   = pres;
    new_dirty  = dirty;
    if (!is_write) begin
      if (dirty && !hit) begin
        targets    = pres;
        tgt_cmd    = CMD_FWD_RD;
        need_grant = 1'b0;
        new_pres   = pres | self_bit;
        new_dirty  = 1'b0;
      end else if (!hit) begin
        new_pres = pres | self_bit;
      end
    end else begin
      if (dirty && !hit) begin
        targets    = pres;
        tgt_cmd    = CMD_FWD_WR;
        need_grant = 1'b0;
        new_pres   = self_bit;
        new_dirty  = 1'b1;
      end else if (!dirty) begin
        targets   = pres & ~self_bit;
        new_pres  = self_bit;
        new_dirty = 1'b1;
      end
    end
  end
endmodule

// File: rtl/dirc_engine.sv
module dirc_engine
  import dirc_pkg::*;
#(
  parameter int NODES = 4,
  parameter int NW    = 2,
  parameter int BW    = 3,
  parameter int CW    = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [NW-1:0]    req_node,
  input  logic [BW-1:0]    req_blk,
  input  logic             ack_valid,
  input  logic             entry_busy,
  input  logic [NODES-1:0] p_targets,
  input  dirc_cmd_e        p_tgt_cmd,
  input  logic             p_need_grant,
  input  dirc_cmd_e        p_grant_cmd,
  input  logic [NODES-1:0] p_new_pres,
  input  logic             p_new_dirty,
  output logic             accept,
  output logic             commit,
  output logic [BW-1:0]    cm_blk,
  output logic [NODES-1:0] cm_pres,
  output logic             cm_dirty,
  output logic             msg_valid,
  output logic [NW-1:0]    msg_dest,
  output logic [2:0]       msg_cmd
);
  dirc_state_e      st_q, st_d;
  logic [NW-1:0]    node_q;
  logic [BW-1:0]    blk_q;
  logic [NODES-1:0] mask_q, mask_d;
  dirc_cmd_e        tcmd_q, gcmd_q;
  logic             grant_q;
  logic [NODES-1:0] npres_q;
  logic             ndirty_q;
  logic [CW-1:0]    cnt_q, cnt_d;
  logic [NW-1:0]    low_idx;
  logic             send;

  always_comb begin
    low_idx = '0;
    for (int i = NODES - 1; i >= 0; i--) begin
      if (mask_q[i]) low_idx = NW'(i);
    end
  end

  assign req_ready = (st_q == ST_IDLE) && !entry_busy;
  assign accept    = req_valid && req_ready;
  assign send      = (st_q == ST_ISSUE);
  assign commit    = (st_q == ST_DONE);
  assign cm_blk    = blk_q;
  assign cm_pres   = npres_q;
  assign cm_dirty  = ndirty_q;

  always_comb begin
    msg_valid = 1'b0;
    msg_dest  = node_q;
    msg_cmd   = CMD_NONE;
    if (st_q == ST_ISSUE) begin
      msg_valid = 1'b1;
      msg_dest  = low_idx;
      msg_cmd   = tcmd_q;
    end else if (st_q == ST_DONE && grant_q) begin
      msg_valid = 1'b1;
      msg_cmd   = gcmd_q;
    end
  end

  always_comb begin
    st_d   = st_q;
    mask_d = mask_q;
    cnt_d  = cnt_q + CW'(send) - CW'(ack_valid && st_q != ST_IDLE);
    case (st_q)
      ST_IDLE: begin
        cnt_d = '0;
        if (accept) begin
          mask_d = p_targets;
          st_d   = (p_targets != '0) ? ST_ISSUE : ST_DONE;
        end
      end
      ST_ISSUE: begin
        mask_d = mask_q & ~(NODES'(1) << low_idx);
        if (mask_d == '0) st_d = (cnt_d == '0) ? ST_DONE : ST_WAIT;
      end
      ST_WAIT: if (cnt_d == '0) st_d = ST_DONE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      mask_q <= '0;
      cnt_q  <= '0;
    end else begin
      st_q   <= st_d;
      mask_q <= mask_d;
      cnt_q  <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      node_q   <= '0;
      blk_q    <= '0;
      tcmd_q   <= CMD_NONE;
      gcmd_q   <= CMD_NONE;
      grant_q  <= 1'b0;
      npres_q  <= '0;
      ndirty_q <= 1'b0;
    end else if (accept) begin
      node_q   <= req_node;
      blk_q    <= req_blk;
      tcmd_q   <= p_tgt_cmd;
      gcmd_q   <= p_grant_cmd;
      grant_q  <= p_need_grant;
      npres_q  <= p_new_pres;
      ndirty_q <= p_new_dirty;
    end
  end
endmodule

// File: rtl/dirc_home.sv
module dirc_home
  import dirc_pkg::*;
#(
  parameter  int NODES  = 4,
  parameter  int BLOCKS = 8,
  localparam int NW     = (NODES > 1) ? $clog2(NODES) : 1,
  localparam int BW     = (BLOCKS > 1) ? $clog2(BLOCKS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [NW-1:0] req_node,
  input  logic [BW-1:0] req_blk,
  output logic          msg_valid,
  output logic [NW-1:0] msg_dest,
  output logic [2:0]    msg_cmd,
  input  logic          ack_valid
);
  localparam int CW = $clog2(NODES + 1);

  logic [NODES-1:0] rd_pres, p_targets, p_new_pres, cm_pres;
  logic             rd_dirty, rd_busy, p_need_grant, p_new_dirty;
  logic             accept, commit, cm_dirty;
  logic [BW-1:0]    cm_blk;
  dirc_cmd_e        p_tgt_cmd, p_grant_cmd;

  dirc_table #(.NODES(NODES), .BLOCKS(BLOCKS), .BW(BW)) u_table (
    .clk(clk), .rst_n(rst_n), .rd_blk(req_blk), .rd_pres(rd_pres),
    .rd_dirty(rd_dirty), .rd_busy(rd_busy), .set_busy(accept),
    .commit(commit), .wr_blk(cm_blk), .wr_pres(cm_pres), .wr_dirty(cm_dirty)
  );

  dirc_plan #(.NODES(NODES), .NW(NW)) u_plan (
    .is_write(req_write), .node(req_node), .pres(rd_pres), .dirty(rd_dirty),
    .targets(p_targets), .tgt_cmd(p_tgt_cmd), .need_grant(p_need_grant),
    .grant_cmd(p_grant_cmd), .new_pres(p_new_pres), .new_dirty(p_new_dirty)
  );

  dirc_engine #(.NODES(NODES), .NW(NW), .BW(BW), .CW(CW)) u_engine (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_node(req_node), .req_blk(req_blk), .ack_valid(ack_valid),
    .entry_busy(rd_busy), .p_targets(p_targets), .p_tgt_cmd(p_tgt_cmd),
    .p_need_grant(p_need_grant), .p_grant_cmd(p_grant_cmd),
    .p_new_pres(p_new_pres), .p_new_dirty(p_new_dirty), .accept(accept),
    .commit(commit), .cm_blk(cm_blk), .cm_pres(cm_pres), .cm_dirty(cm_dirty),
    .msg_valid(msg_valid), .msg_dest(msg_dest), .msg_cmd(msg_cmd)
  );
endmodule

// File: rtl/dirc_home_chk.sv
module dirc_home_chk #(
  parameter int NW = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_ready,
  input logic [NW-1:0] req_node,
  input logic          msg_valid,
  input logic [NW-1:0] msg_dest,
  input logic [2:0]    msg_cmd
);
  logic [NW-1:0] held_node;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) held_node <= '0;
    else if (req_valid && req_ready) held_node <= req_node;
  end

  assert_grant_to_requester_R2: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && (msg_cmd == 3'd1 || msg_cmd == 3'd2) |-> msg_dest == held_node);

  assert_no_self_inval_R4: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && msg_cmd == 3'd3 |-> msg_dest != held_node);

  assert_msg_only_when_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid |-> !req_ready);

  assert_accept_sets_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> !req_ready);

  assert_ready_after_grant_R8: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && (msg_cmd == 3'd1 || msg_cmd == 3'd2) |=> req_ready);

  assert_known_cmd_R1: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid |-> (msg_cmd >= 3'd1 && msg_cmd <= 3'd5));
endmodule

bind dirc_home dirc_home_chk #(.NW(NW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_node(req_node), .msg_valid(msg_valid), .msg_dest(msg_dest),
  .msg_cmd(msg_cmd)
);

// File: tb/dirc_home_tb_top.sv
module dirc_home_tb_top;
  logic       clk;
  logic       rst_n;
  logic       req_valid, req_ready, req_write, msg_valid, ack_valid;
  logic [1:0] req_node, msg_dest;
  logic [2:0] req_blk, msg_cmd;

  int n_checks = 0;
  int n_fail   = 0;
  int cycles   = 0;

  int log_n = 0;
  int log_dest [32];
  int log_cmd  [32];
  int exp_n = 0;
  int exp_dest [8];
  int exp_cmd  [8];

  dirc_home #(.NODES(4), .BLOCKS(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_node(req_node), .req_blk(req_blk),
    .msg_valid(msg_valid), .msg_dest(msg_dest), .msg_cmd(msg_cmd),
    .ack_valid(ack_valid)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  always @(negedge clk) begin
    if (rst_n && msg_valid && log_n < 32) begin
      log_dest[log_n] = int'(msg_dest);
      log_cmd[log_n]  = int'(msg_cmd);
      log_n = log_n + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic expect_msg(input int d, input int c);
    exp_dest[exp_n] = d;
    exp_cmd[exp_n]  = c;
    exp_n++;
  endtask

  // Issue one request, return acknowledgements, then compare the message log.
  task automatic run(input string req, input int node, input int blk,
                     input bit wr, input int n_acks);
    @(negedge clk);
    #1;
    chk(req_ready == 1'b1, "R8 ready before request", int'(req_ready), 1);
    log_n     = 0;
    req_valid = 1'b1;
    req_write = wr;
    req_node  = 2'(node);
    req_blk   = 3'(blk);
    @(negedge clk);
    req_valid = 1'b0;
    #1;
    chk(req_ready == 1'b0, "R8 busy after accept", int'(req_ready), 0);
    repeat (5) @(negedge clk);
    for (int a = 0; a < n_acks; a++) begin
      #1;
      chk(req_ready == 1'b0, "R8 busy while acks outstanding", int'(req_ready), 0);
      ack_valid = 1'b1;
      @(negedge clk);
      ack_valid = 1'b0;
    end
    repeat (3) @(negedge clk);
    #1;
    chk(req_ready == 1'b1, "R8 ready after completion", int'(req_ready), 1);
    chk(log_n == exp_n, {req, " message count"}, log_n, exp_n);
    for (int i = 0; i < exp_n; i++) begin
      if (i < log_n) begin
        chk(log_dest[i] == exp_dest[i], {req, " destination"}, log_dest[i], exp_dest[i]);
        chk(log_cmd[i] == exp_cmd[i], {req, " command"}, log_cmd[i], exp_cmd[i]);
      end
    end
    exp_n = 0;
  endtask

  task automatic t_reset;
    #1;
    chk(req_ready == 1'b1, "R1 ready at reset", int'(req_ready), 1);
    chk(msg_valid == 1'b0, "R1 no message at reset", int'(msg_valid), 0);
  endtask

  task automatic t_read_clean;
    expect_msg(1, 1); run("R2 read clean", 1, 2, 1'b0, 0);
    expect_msg(1, 2); run("R3 reread by sharer", 1, 2, 1'b0, 0);
  endtask

  task automatic t_write_shared;
    expect_msg(2, 1); run("R2 read by node2", 2, 5, 1'b0, 0);
    expect_msg(0, 1); run("R2 read by node0", 0, 5, 1'b0, 0);
    expect_msg(1, 1); run("R2 read by node1", 1, 5, 1'b0, 0);
    expect_msg(0, 3); expect_msg(1, 3); expect_msg(2, 3); expect_msg(3, 1);
    run("R4 write to shared block", 3, 5, 1'b1, 3);
  endtask

  task automatic t_write_upgrade;
    expect_msg(3, 1); run("R2 read by node3", 3, 2, 1'b0, 0);
    expect_msg(3, 3); expect_msg(1, 2);
    run("R4 upgrade by sharer", 1, 2, 1'b1, 1);
    expect_msg(1, 4); run("R5 writer sole owner", 0, 2, 1'b0, 1);
  endtask

  task automatic t_read_dirty;
    expect_msg(3, 4); run("R6 read to dirty block", 0, 5, 1'b0, 1);
    expect_msg(0, 3); expect_msg(3, 3); expect_msg(2, 1);
    run("R6 owner and reader now sharers", 2, 5, 1'b1, 2);
  endtask

  task automatic t_owner_write;
    expect_msg(2, 2); run("R3 write by dirty owner", 2, 5, 1'b1, 0);
    expect_msg(2, 2); run("R3 read by dirty owner", 2, 5, 1'b0, 0);
  endtask

  task automatic t_write_dirty;
    expect_msg(2, 5); run("R7 write to dirty block", 1, 5, 1'b1, 1);
    expect_msg(1, 4); run("R7 new owner after forward", 0, 5, 1'b0, 1);
  endtask

  initial begin
    rst_n     = 1'b0;
    req_valid = 1'b0;
    req_write = 1'b0;
    req_node  = '0;
    req_blk   = '0;
    ack_valid = 1'b0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_read_clean();
    t_write_shared();
    t_write_upgrade();
    t_read_dirty();
    t_owner_write();
    t_write_dirty();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 20000) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, 20000);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule